// File: doc/BRIEF.md
# Regulator soft-start and hiccup sequencer

This block is the digital supervisor of a synchronous buck regulator. It takes flags that have already been synchronised from the analog comparators: supply under-voltage ok, enable ok, over-current and over-temperature. It also takes a strobe that marks each switching cycle and a level that is high while the low-side switch is on. From these it drives four outputs. The first is a soft-start code that feeds the reference DAC. The second is a flag that marks the end of the ramp. The third is a gate-driver enable. The fourth is a control that puts the drivers into the high-impedance state.

Power-on-ready is the AND of the supply and enable flags. When it is high and no fault is present, the soft-start code climbs by one LSB every `STEP_DIV` clocks from zero to full scale. The over-current flag is looked at only while the low-side switch is on, and never in the first `BLANK_CYC` clocks after it turns on. Once an over-current event is accepted, the block latches it. The drivers turn off, the ramp is forced to zero, and it stays there for `HICCUP_CYC` switching cycles before a fresh soft-start begins. An over-temperature flag stops switching and clears the ramp. The block restarts on its own when the flag drops.

Top module: `ss_sequencer`

## Requirements
- R1: `drv_en_o` is 1 exactly when uv_ok_i=1, en_ok_i=1, ot_i=0 and no hiccup hold is in progress. This output is combinational from those inputs and the hiccup state.
- R2: `drv_hiz_o` is the inverse of `en_ok_i` in the same cycle, whatever the other inputs are.
- R3: In any clock in which the drivers are not enabled, or in which an over-current is accepted, the ramp resets at the next edge. After that edge `ss_code_o` is 0 and the step prescaler is cleared.
- R4: After n consecutive clock edges with the drivers enabled, `ss_code_o` equals min(floor(n / STEP_DIV), 2^CODE_W - 1). It never wraps.
- R5: `ss_done_o` is 1 exactly when `ss_code_o` equals the all-ones full-scale code.
- R6: `oc_i` is ignored while `lsfet_on_i` is 0. It is also ignored on the first `BLANK_CYC` clock edges at which `lsfet_on_i` is 1 after a 0. It is accepted from the next edge onward.
- R7: An accepted over-current sets the hiccup hold at that edge. After it, `drv_en_o` is 0 and `ss_code_o` is 0.
- R8: During the hiccup hold, the block counts clock edges with `cycle_i` = 1. The count starts at the edge after acceptance. At the edge of the `HICCUP_CYC`-th such strobe the hold clears, `drv_en_o` returns to 1, and the ramp starts again from code 0.
- R9: If the over-current is still present after a restart, the same blanking and acceptance apply again and trip a new hiccup hold. The cycle repeats for as long as the fault lasts.
- R10: While `ot_i` is 1, `drv_en_o` is 0 and the ramp is held at zero. When `ot_i` drops, the ramp restarts from 0 with no further action.
- R11: Loss of power-on-ready during a hiccup hold cancels the hold at the next edge. When power-on-ready returns, the drivers are enabled without waiting for the hiccup count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| uv_ok_i | input | 1 | Supply above its under-voltage threshold |
| en_ok_i | input | 1 | Enable above its threshold |
| oc_i | input | 1 | Over-current comparator output |
| ot_i | input | 1 | Over-temperature trip |
| cycle_i | input | 1 | One-clock strobe per switching cycle |
| lsfet_on_i | input | 1 | Low-side switch is on |
| ss_code_o | output | CODE_W | Soft-start DAC code |
| ss_done_o | output | 1 | Ramp at full scale |
| drv_en_o | output | 1 | Gate drivers may switch |
| drv_hiz_o | output | 1 | Gate drivers to high impedance |

## Verification
Suppose the prescaler or code register is corrupted. The ramp would show it within one `STEP_DIV` period, as a code that is off its floor(n/STEP_DIV) staircase or that passes full scale. Suppose the blanking counter is miscounted. An over-current would then drop `drv_en_o` one edge too early or too late compared with the `BLANK_CYC` boundary. Suppose the hiccup counter or latch goes wrong. That would show only at the end of the hold, when `drv_en_o` comes back on a strobe count other than `HICCUP_CYC`, or when a loss of power-on-ready fails to cancel the hold.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_RAMP   = 2'd1,
    SEQ_FULL   = 2'd2,
    SEQ_HICCUP = 2'd3
  } seq_phase_e;
endpackage

// File: rtl/ss_oc_blank.sv
module ss_oc_blank #(
  parameter int unsigned BLANK_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lsfet_on_i,
  input  logic oc_i,
  output logic accept_o
);
  localparam int unsigned CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC - 1);

  logic          ls_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise     = lsfet_on_i & ~ls_q;
  assign accept_o = oc_i & lsfet_on_i & ~rise & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ls_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      ls_q <= lsfet_on_i;
      if (rise)              cnt_q <= LOAD;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  // R6
  blank_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsfet_on_i && !ls_q) |-> !accept_o);
  // R6
  blank_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (lsfet_on_i && oc_i));
endmodule

// File: rtl/ss_hiccup.sv
module ss_hiccup #(
  parameter int unsigned HICCUP_CYC = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  input  logic arm_i,
  input  logic trip_i,
  input  logic cycle_i,
  output logic hold_o
);
  localparam int unsigned CW = (HICCUP_CYC > 1) ? $clog2(HICCUP_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HICCUP_CYC - 1);

  logic          hold_q;
  logic [CW-1:0] cnt_q;

  assign hold_o = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!por_i) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (hold_q) begin
      if (cycle_i) begin
        if (cnt_q == LAST) begin
          hold_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end else if (trip_i && arm_i) begin
      hold_q <= 1'b1;
    end
  end

  // R7
  trip_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_i && arm_i && trip_i && !hold_q) |=> hold_q);
  // R8
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && por_i && !cycle_i) |=> hold_q);
  // R11
  por_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_i |=> !hold_q);
endmodule

// File: rtl/ss_ramp.sv
module ss_ramp #(
  parameter int unsigned CODE_W   = 12,
  parameter int unsigned STEP_DIV = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  output logic [CODE_W-1:0] code_o,
  output logic              full_o
);
  localparam int unsigned PW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [PW-1:0]     PLAST = PW'(STEP_DIV - 1);
  localparam logic [CODE_W-1:0] FULL  = '1;

  logic [PW-1:0]     presc_q;
  logic [CODE_W-1:0] code_q;
  logic              tick;

  assign tick   = (presc_q == PLAST);
  assign code_o = code_q;
  assign full_o = (code_q == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      code_q  <= '0;
    end else if (!run_i) begin
      presc_q <= '0;
      code_q  <= '0;
    end else begin
      presc_q <= tick ? '0 : presc_q + 1'b1;
      if (tick && !full_o) code_q <= code_q + 1'b1;
    end
  end

  // R3
  ramp_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (code_q == '0));
  // R4
  ramp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> (code_q == $past(code_q)) ||
              (code_q == $past(code_q) + 1'b1 && $past(code_q) != FULL));
endmodule

// File: rtl/ss_sequencer.sv
module ss_sequencer
  import ss_pkg::*;
#(
  parameter int unsigned CODE_W     = 12,
  parameter int unsigned STEP_DIV   = 16,
  parameter int unsigned BLANK_CYC  = 50,
  parameter int unsigned HICCUP_CYC = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              uv_ok_i,
  input  logic              en_ok_i,
  input  logic              oc_i,
  input  logic              ot_i,
  input  logic              cycle_i,
  input  logic              lsfet_on_i,
  output logic [CODE_W-1:0] ss_code_o,
  output logic              ss_done_o,
  output logic              drv_en_o,
  output logic              drv_hiz_o
);
  logic       por;
  logic       no_fault;
  logic       accept;
  logic       hold;
  logic       full;
  logic       ramp_run;
  seq_phase_e phase;

  assign por      = uv_ok_i & en_ok_i;
  assign no_fault = por & ~ot_i;

  always_comb begin
    if (!no_fault)  phase = SEQ_IDLE;
    else if (hold)  phase = SEQ_HICCUP;
    else if (full)  phase = SEQ_FULL;
    else            phase = SEQ_RAMP;
  end

  assign drv_en_o  = (phase == SEQ_RAMP) || (phase == SEQ_FULL);
  assign drv_hiz_o = ~en_ok_i;
  assign ramp_run  = drv_en_o & ~accept;
  assign ss_done_o = full;

  ss_oc_blank #(.BLANK_CYC(BLANK_CYC)) i_blank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lsfet_on_i (lsfet_on_i),
    .oc_i       (oc_i),
    .accept_o   (accept)
  );

  ss_hiccup #(.HICCUP_CYC(HICCUP_CYC)) i_hiccup (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .por_i   (por),
    .arm_i   (no_fault),
    .trip_i  (accept),
    .cycle_i (cycle_i),
    .hold_o  (hold)
  );

  ss_ramp #(.CODE_W(CODE_W), .STEP_DIV(STEP_DIV)) i_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ramp_run),
    .code_o (ss_code_o),
    .full_o (full)
  );

  // R1
  drv_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en_o |-> (uv_ok_i && en_ok_i && !ot_i));
  // R5
  done_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ss_done_o) |-> $past(drv_en_o));
  // R10
  ot_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_i |=> (ss_code_o == '0));
endmodule

// File: tb/test_ss_sequencer.sv
module test_ss_sequencer;
  localparam int unsigned W    = 4;
  localparam int unsigned D    = 3;
  localparam int unsigned B    = 5;
  localparam int unsigned H    = 8;
  localparam int unsigned FULL = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv_ok = 1'b0, en_ok = 1'b0, oc = 1'b0, ot = 1'b0, cyc = 1'b0, lsfet = 1'b0;
  logic [W-1:0] code;
  logic done, drv_en, drv_hiz;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ss_sequencer #(.CODE_W(W), .STEP_DIV(D), .BLANK_CYC(B), .HICCUP_CYC(H)) i_ss_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .uv_ok_i(uv_ok), .en_ok_i(en_ok), .oc_i(oc),
    .ot_i(ot), .cycle_i(cyc), .lsfet_on_i(lsfet), .ss_code_o(code),
    .ss_done_o(done), .drv_en_o(drv_en), .drv_hiz_o(drv_hiz)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int n = 0; n < 200000; n++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("reset code", int'(code), 0);
    chk("reset done", int'(done), 0);
    chk("reset drv_en", int'(drv_en), 0);
    chk("R2 reset hiz", int'(drv_hiz), 1);
    rst_n = 1'b1;
    step();

    // R1 R2: sweep flag combinations, low-side off so oc never accepted
    for (int v = 0; v < 16; v++) begin
      {uv_ok, en_ok, oc, ot} = 4'(v);
      #1;
      chk("R2 hiz", int'(drv_hiz), int'(!en_ok));
      chk("R1 drv_en", int'(drv_en), int'(uv_ok && en_ok && !ot));
      step();
    end

    // R3 R4 R5: full ramp staircase
    uv_ok = 1'b1; en_ok = 1'b0; oc = 1'b0; ot = 1'b0;
    step();
    chk("R3 cleared", int'(code), 0);
    en_ok = 1'b1;
    for (int n = 1; n <= int'(FULL * D) + 6; n++) begin
      step();
      chk("R4 code", int'(code), (n / D > FULL) ? FULL : n / D);
      chk("R5 done", int'(done), int'((n / D) >= FULL));
    end

    // R6 R7: oc held with low-side on, blanked then accepted
    lsfet = 1'b1; oc = 1'b1;
    for (int n = 1; n <= B; n++) begin
      step();
      chk("R6 blanked", int'(drv_en), 1);
    end
    lsfet = 1'b0;
    step();
    chk("R6 lsfet low", int'(drv_en), 1);
    lsfet = 1'b1;
    for (int n = 1; n <= B; n++) step();
    chk("R6 still blanked", int'(drv_en), 1);
    step();
    chk("R7 drv off", int'(drv_en), 0);
    chk("R7 code zero", int'(code), 0);
    lsfet = 1'b0; oc = 1'b0;

    // R8: count strobes
    for (int s = 1; s <= H; s++) begin
      step(); step();
      cyc = 1'b1;
      step();
      cyc = 1'b0;
      chk("R8 hold", int'(drv_en), int'(s == H));
      chk("R8 code", int'(code), 0);
    end
    for (int n = 1; n <= D; n++) step();
    chk("R8 restart ramp", int'(code), 1);

    // R9: fault persists, trips again
    lsfet = 1'b1; oc = 1'b1;
    for (int n = 1; n <= B; n++) step();
    chk("R9 blanked", int'(drv_en), 1);
    step();
    chk("R9 retrip", int'(drv_en), 0);
    lsfet = 1'b0; oc = 1'b0;

    // R11: power-on-ready loss cancels hold
    uv_ok = 1'b0;
    step();
    uv_ok = 1'b1;
    #1;
    chk("R11 cancel", int'(drv_en), 1);
    for (int n = 1; n <= 2 * D; n++) step();
    chk("R11 ramp", int'(code), 2);

    // R10: over-temperature
    ot = 1'b1;
    #1;
    chk("R10 drv off", int'(drv_en), 0);
    step();
    chk("R10 code zero", int'(code), 0);
    step();
    ot = 1'b0;
    #1;
    chk("R10 drv back", int'(drv_en), 1);
    for (int n = 1; n <= D; n++) step();
    chk("R10 restart", int'(code), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule